// File: doc/BRIEF.md
# Serial-Loaded Octal Converter Register Interface

This block is the digital front end of an eight-channel, 12-bit, double-buffered converter. A host sends 16-bit command words over a framed serial port. Each word holds a 12-bit code, one device-address bit and a 3-bit channel number. When the address bit matches the strapped address input, the code is written into that channel's input latch. A level-sensitive load strobe copies all eight input latches into the output latches at once. A clear strobe forces every output latch to zero.

Every bit that enters the shift register leaves it again on a serial output 16 clock falls later. Several devices can therefore share one data line in a daisy chain. All serial and strobe pins are asynchronous to the block. They pass through two-flop synchronizers on a fast system clock, and the block detects serial-clock falling edges itself. The eight output latches drive a flat parallel bus.

Top module: `odac_front`

## Requirements
- R1: After a synchronous active-low reset, every input latch and every output latch holds zero, and `ser_dout` is 0.
- R2: The shift register moves only on a falling edge of `ser_clk` while `frame_n` is low. Clock edges while `frame_n` is high shift nothing and write nothing.
- R3: A frame is sent MSB first. Bits 15..4 are the code, bit 3 is the address bit and bits 2..0 select the channel. Select code k (000 to 111) writes channel k, which appears on `ch_out[k*12 +: 12]`. The write happens on the sixteenth falling edge after `frame_n` goes low.
- R4: A frame whose address bit differs from `dev_addr` changes no input latch.
- R5: `ser_dout` always shows the bit shifted in 16 qualifying falls earlier, whether or not the address matched. It changes only in response to a `ser_clk` falling edge.
- R6: A write to an input latch leaves `ch_out` unchanged. While `load_n` is low (and `clear_n` is high), every output latch takes its input latch value. With both strobes high, `ch_out` holds.
- R7: While `clear_n` is low, all output latches are zero. The input latches keep their values, so a later load restores them.
- R8: When `clear_n` and `load_n` are both low, clear wins and the outputs stay zero.
- R9: If `frame_n` rises before the sixteenth edge, the partial frame writes nothing and the bit count restarts at the next frame.
- R10: Falling edges after the sixteenth in the same low frame keep shifting toward `ser_dout` but cause no further write.
- R11: A low level on `load_n` or `clear_n` is visible on `ch_out` within three system clocks of the pin changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| frame_n | input | 1 | Active-low frame enable |
| ser_din | input | 1 | Serial data in, MSB first |
| dev_addr | input | 1 | Strapped device address compared with frame bit 3 |
| load_n | input | 1 | Active-low simultaneous transfer strobe |
| clear_n | input | 1 | Active-low clear of all output latches |
| ser_dout | output | 1 | Daisy-chain serial output |
| ch_out | output | 96 | Eight 12-bit output latch values, channel k at bits k*12+11..k*12 |

## Verification
The bench sweeps every channel select against both address-bit values and both strap settings. It checks `ser_dout` before every falling edge against a bench-side 16-bit shadow register. A design that decoded the select backwards, ignored the address bit, or dropped the daisy-chain path on a mismatch would show a wrong channel or a wrong serial bit. An aborted 10-bit frame followed by a full frame catches a counter that never restarts: such a counter would write a mixed word six bits into the second frame. A 20-bit frame catches a design that writes on every sixteenth-or-later edge. Holding clear and load low together catches a design that lets the load win. Reloading after a clear catches a clear that wrongly wipes the input latches.

// File: rtl/odac_pkg.sv
// Shared constants and helpers for the octal converter front end.
// Assumes one device-address bit per frame.
package odac_pkg;
    localparam int unsigned ADDR_BITS = 1;

    // Total frame length for a given code width and select width.
    function automatic int unsigned frame_len(input int unsigned dw, input int unsigned sw);
        return dw + ADDR_BITS + sw;
    endfunction
endpackage

// File: rtl/odac_sync.sv
// Two-flop synchronizer for a bundle of independent asynchronous levels.
// Assumes each bit is a slow level or edge. Bits are not treated as a coherent word.
module odac_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages that reset to the idle level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/odac_serial_rx.sv
// Framed serial receiver: detects serial-clock falls, shifts data while the frame
// is low, and issues one write pulse on the last bit of a frame.
// Assumes synchronized inputs and a serial clock several system clocks per phase.
module odac_serial_rx #(
    parameter int unsigned FRAME_W = 16,
    localparam int unsigned CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               frm_s,
    input  logic               din_s,
    output logic               fall,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic [FRAME_W-1:0] shreg,
    output logic               wr_en,
    output logic [FRAME_W-1:0] wr_word
);
    logic sclk_q;
    logic last_bit;

    assign fall     = sclk_q & ~sclk_s;
    assign last_bit = fall && !frm_s && (bit_cnt == CNT_W'(FRAME_W - 1));

    // Previous serial-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b1;
        else        sclk_q <= sclk_s;
    end

    // Shift register and saturating bit counter, cleared by a high frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (frm_s) begin
            bit_cnt <= '0;
        end else if (fall) begin
            shreg <= {shreg[FRAME_W-2:0], din_s};
            if (bit_cnt != CNT_W'(FRAME_W)) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Capture the completed word and pulse the write request once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_word <= '0;
        end else begin
            wr_en <= last_bit;
            if (last_bit) wr_word <= {shreg[FRAME_W-2:0], din_s};
        end
    end
endmodule

// File: rtl/odac_latch_bank.sv
// Double-buffered latch bank: per-channel input latches written by address,
// and output latches loaded together or cleared together.
// Assumes active-low synchronized strobes. Clear outranks load.
module odac_latch_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned SEL_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     addr_ok,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     ld_s,
    input  logic                     clr_s,
    output logic [NUM_CH*DATA_W-1:0] in_flat,
    output logic [NUM_CH*DATA_W-1:0] out_flat
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Input latch c takes the code when a matching write selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                in_flat[c*DATA_W +: DATA_W] <= '0;
            else if (wr_en && addr_ok && (wr_sel == SEL_W'(c)))
                in_flat[c*DATA_W +: DATA_W] <= wr_data;
        end

        // Output latch c: clear first, then level-sensitive load.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_flat[c*DATA_W +: DATA_W] <= '0;
            else if (!clr_s)
                out_flat[c*DATA_W +: DATA_W] <= '0;
            else if (!ld_s)
                out_flat[c*DATA_W +: DATA_W] <= in_flat[c*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/odac_front.sv
// Top of the octal converter register interface. It synchronizes the pins,
// receives framed serial words, checks the address bit and drives the latch bank.
// Assumes NUM_CH is a power of two and dev_addr is static.
module odac_front #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned SEL_W   = $clog2(NUM_CH),
    localparam int unsigned FRAME_W = odac_pkg::frame_len(DATA_W, SEL_W),
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     frame_n,
    input  logic                     ser_din,
    input  logic                     dev_addr,
    input  logic                     load_n,
    input  logic                     clear_n,
    output logic                     ser_dout,
    output logic [NUM_CH*DATA_W-1:0] ch_out
);
    logic [4:0]               sync_q;
    logic                     sclk_s, frm_s, din_s, ld_s, clr_s;
    logic                     fall;
    logic [CNT_W-1:0]         bit_cnt;
    logic [FRAME_W-1:0]       shreg;
    logic                     wr_en;
    logic [FRAME_W-1:0]       wr_word;
    logic                     addr_ok;
    logic [NUM_CH*DATA_W-1:0] in_flat;

    odac_sync #(.W(5), .RST_VAL(5'b11011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, frame_n, ser_din, load_n, clear_n}),
        .q     (sync_q)
    );
    assign {sclk_s, frm_s, din_s, ld_s, clr_s} = sync_q;

    odac_serial_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .frm_s   (frm_s),
        .din_s   (din_s),
        .fall    (fall),
        .bit_cnt (bit_cnt),
        .shreg   (shreg),
        .wr_en   (wr_en),
        .wr_word (wr_word)
    );

    assign addr_ok  = (wr_word[SEL_W] == dev_addr);
    assign ser_dout = shreg[FRAME_W-1];

    odac_latch_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr_ok  (addr_ok),
        .wr_sel   (wr_word[SEL_W-1:0]),
        .wr_data  (wr_word[FRAME_W-1 -: DATA_W]),
        .ld_s     (ld_s),
        .clr_s    (clr_s),
        .in_flat  (in_flat),
        .out_flat (ch_out)
    );
endmodule

// File: rtl/odac_front_chk.sv
// Property checker for odac_front, attached through bind. It observes the
// synchronized strobes, receiver state and latch buses.
module odac_front_chk #(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned CNT_W   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clr_s,
    input logic                     ld_s,
    input logic                     frm_s,
    input logic                     fall,
    input logic                     wr_en,
    input logic                     addr_ok,
    input logic [CNT_W-1:0]         bit_cnt,
    input logic                     ser_dout,
    input logic [NUM_CH*DATA_W-1:0] in_flat,
    input logic [NUM_CH*DATA_W-1:0] ch_out
);
    // R8 / R7: a synchronized clear zeroes every output on the next cycle.
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (ch_out == '0));

    // R6: with both strobes idle the outputs hold.
    a_r6_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && clr_s) |=> $stable(ch_out));

    // R4: a write with a mismatched address leaves the input latches alone.
    a_r4_mismatch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_ok) |=> $stable(in_flat));

    // R5: the serial output moves only after a detected falling edge.
    a_r5_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(ser_dout));

    // R3 / R10: a write request appears only with a full frame counted.
    a_r3_write_at_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (bit_cnt == CNT_W'(FRAME_W)));

    // R9: a high frame restarts the bit count.
    a_r9_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frm_s |=> (bit_cnt == '0));
endmodule

bind odac_front odac_front_chk #(
    .NUM_CH  (NUM_CH),
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_s    (clr_s),
    .ld_s     (ld_s),
    .frm_s    (frm_s),
    .fall     (fall),
    .wr_en    (wr_en),
    .addr_ok  (addr_ok),
    .bit_cnt  (bit_cnt),
    .ser_dout (ser_dout),
    .in_flat  (in_flat),
    .ch_out   (ch_out)
);

// File: tb/odac_front_tb_top.sv
// Self-checking bench for odac_front: channel/address sweep, daisy-chain shadow,
// framing corner cases and strobe priority.
module odac_front_tb_top;
    localparam int NCH = 8;
    localparam int DW  = 12;
    localparam int HP  = 8;   // system clocks per serial-clock phase

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_clk = 1'b1;
    logic          frame_n = 1'b1;
    logic          ser_din = 1'b0;
    logic          dev_addr = 1'b1;
    logic          load_n = 1'b1;
    logic          clear_n = 1'b1;
    logic          ser_dout;
    logic [NCH*DW-1:0] ch_out;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    logic [DW-1:0] in_m  [NCH];
    logic [DW-1:0] out_m [NCH];
    logic [15:0]   sh_m = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    odac_front dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .frame_n  (frame_n),
        .ser_din  (ser_din),
        .dev_addr (dev_addr),
        .load_n   (load_n),
        .clear_n  (clear_n),
        .ser_dout (ser_dout),
        .ch_out   (ch_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        for (int c = 0; c < NCH; c++)
            chk(req, $sformatf("ch_out[%0d]", c), 32'(ch_out[c*DW +: DW]), 32'(out_m[c]));
    endtask

    // Shift n bits, MSB first; check ser_dout against the shadow before each fall (R5).
    task automatic send_bits(input logic [31:0] bits, input int n);
        logic [15:0] w;
        frame_n = 1'b0;
        wait_clk(HP);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i];
            wait_clk(HP);
            chk("R5", "ser_dout before fall", 32'(ser_dout), 32'(sh_m[15]));
            ser_clk = 1'b0;
            sh_m = {sh_m[14:0], bits[i]};
            wait_clk(HP);
            ser_clk = 1'b1;
        end
        wait_clk(HP);
        frame_n = 1'b1;
        wait_clk(HP);
        if (n >= 16) begin
            w = 16'(bits >> (n - 16));
            if (w[3] == dev_addr) in_m[w[2:0]] = w[15:4];
        end
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_clk(4);
        load_n = 1'b1;
        wait_clk(4);
        for (int c = 0; c < NCH; c++) out_m[c] = in_m[c];
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            in_m[c]  = '0;
            out_m[c] = '0;
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1: reset state.
        check_outs("R1");
        chk("R1", "ser_dout after reset", 32'(ser_dout), 32'd0);

        // R3 R4 R5 R6: sweep strap, address bit and every channel.
        for (int s = 0; s < 2; s++) begin
            dev_addr = s[0];
            wait_clk(4);
            for (int a = 0; a < 2; a++) begin
                for (int c = 0; c < NCH; c++) begin
                    logic [11:0] d;
                    logic [15:0] w;
                    d = 12'((c * 341) + (a * 1234) + (s * 77) + 5);
                    w = {d, a[0], c[2:0]};
                    send_bits(32'(w), 16);
                    // R6: no change on ch_out before the load strobe.
                    check_outs("R6");
                    pulse_load();
                    // R3 on a match, R4 on a mismatch.
                    check_outs((a == s) ? "R3" : "R4");
                end
            end
        end

        // R2: clock toggles with the frame high shift and write nothing.
        ser_din = ~sh_m[15];
        for (int i = 0; i < 20; i++) begin
            ser_clk = 1'b0;
            wait_clk(HP);
            ser_clk = 1'b1;
            wait_clk(HP);
        end
        chk("R2", "ser_dout with frame high", 32'(ser_dout), 32'(sh_m[15]));
        pulse_load();
        check_outs("R2");

        // R9: an aborted 10-bit frame, then a full frame to channel 2.
        dev_addr = 1'b1;
        wait_clk(4);
        send_bits(32'h3FF, 10);
        send_bits(32'({12'h6C1, 1'b1, 3'd2}), 16);
        pulse_load();
        check_outs("R9");

        // R10: 20 edges in one frame; only the first 16 bits are written (channel 5).
        send_bits(32'h5A3D6, 20);
        pulse_load();
        check_outs("R10");
        chk("R10", "ch5 value", 32'(ch_out[5*DW +: DW]), 32'h5A3);

        // R11 R7: clear latency, then the inputs survive the clear.
        clear_n = 1'b0;
        wait_clk(3);
        for (int c = 0; c < NCH; c++) out_m[c] = '0;
        check_outs("R11");
        clear_n = 1'b1;
        wait_clk(4);
        check_outs("R7");
        send_bits(32'({12'h0F0, 1'b1, 3'd7}), 16);
        load_n = 1'b0;
        wait_clk(3);
        for (int c = 0; c < NCH; c++) out_m[c] = in_m[c];
        check_outs("R11");
        load_n = 1'b1;
        wait_clk(4);
        check_outs("R7");

        // R8: clear and load together keep the outputs at zero.
        clear_n = 1'b0;
        load_n  = 1'b0;
        wait_clk(6);
        for (int c = 0; c < NCH; c++) out_m[c] = '0;
        check_outs("R8");
        clear_n = 1'b1;
        load_n  = 1'b1;
        wait_clk(4);
        check_outs("R8");
        pulse_load();
        check_outs("R8");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule